// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address by reading a two-level page table held in memory. A request carries the linear address, an access type (read or write) and a privilege level (user or supervisor). The walker takes the directory base from a base-register input. It fetches the directory entry and then the table entry over a 32-bit memory port, and it reports either a physical address or a page fault. Lookup caching, segmentation and fault dispatch are handled by other blocks.

During a walk the block keeps the status bits of the entries up to date. An accessed bit that is clear is set in any entry on the path. A dirty bit that is clear is set in the leaf entry on a write. Each of these updates is a read-modify-write of the entry, done before the result is returned. When an entry is not present, or when the privilege check fails, the walk ends in a fault and the linear address is held in a fault-address register. Only one walk runs at a time, and a busy flag holds off new requests.

Top module: `ptw_walker`

## Requirements
- R1: The directory entry read goes to `{pdbr_i[31:12], 12'h000} + lin[31:22]*4`, using the base value sampled when the request is accepted.
- R2: The table entry read goes to `{pde[31:12], 12'h000} + lin[21:12]*4`, where pde is the directory entry that was read.
- R3: A successful walk ends with `done_o` high for one cycle, `fault_o` low and `phys_o = {pte[31:12], lin[11:0]}`.
- R4: If the directory entry or the table entry has its present bit (bit 0) clear, the walk ends with `done_o` and `fault_o` both high and `fault_addr_o` equal to the linear address. No further memory access is made for that walk.
- R5: A present directory entry with its accessed bit (bit 5) clear is written back to the same address as the read value OR 0x20, before the table entry is read. The dirty bit (bit 6) is never set in a directory entry, even on a write access. No write-back is made if bit 5 is already set.
- R6: A present table entry is written back as the read value OR 0x20, also OR 0x40 for a write access, only when that value differs from the value read. The write-back comes before `done_o`.
- R7: With the user/supervisor bit at bit 2 and the read/write bit at bit 1 of either entry, a user access to an entry with bit 2 clear faults, and a user write to an entry with bit 1 clear faults. Neither fault writes back the entry. A supervisor access never takes a protection fault.
- R8: `busy_o` is high from the cycle after a request is accepted until the cycle in which `done_o` is high, when it is low. A request presented while `busy_o` is high is ignored.
- R9: `mem_req_o`, `mem_addr_o`, `mem_we_o` and `mem_wdata_o` stay unchanged until `mem_ready_i` is sampled high. Every address is word aligned.
- R10: After reset, `busy_o`, `done_o`, `fault_o` and `mem_req_o` are low and `fault_addr_o` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request, accepted when not busy |
| req_lin_i | input | 32 | Linear address to translate |
| req_write_i | input | 1 | 1 = write access |
| req_user_i | input | 1 | 1 = user privilege, 0 = supervisor |
| pdbr_i | input | 32 | Page directory base (low 12 bits ignored) |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | Completed walk ended in a page fault |
| phys_o | output | 32 | Translated physical address |
| fault_addr_o | output | 32 | Linear address of the latest fault |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_ready_i | input | 1 | Memory accepts the access; read data is valid in the same cycle |
| mem_rdata_i | input | 32 | Read data |

## Verification
The hardest path to reach is a walk that writes back both entries, or one that writes back the directory and then faults on the table entry. Both need a directory entry with its accessed bit clear, a table entry in a chosen state and the right privilege and access type, all in one request. The bench sets up memory images so that the same table pages are walked again and again. The status bits that earlier walks wrote then decide whether the later walks write back. A memory model whose ready delay changes between accesses checks that the request is held while it waits. A request pulse during a walk checks that it is ignored.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIR_RD,
    ST_DIR_WB,
    ST_TBL_RD,
    ST_TBL_WB
  } walk_state_e;

  localparam int unsigned BIT_PRESENT = 0;
  localparam int unsigned BIT_WRITABLE = 1;
  localparam int unsigned BIT_USER = 2;
  localparam int unsigned BIT_ACCESSED = 5;
  localparam int unsigned BIT_DIRTY = 6;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int unsigned AW = 32,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned IDX_W = 10,
  parameter int unsigned ENT_LOG2 = 2
) (
  input  logic [AW-OFF_W-1:0] frame_i,
  input  logic [IDX_W-1:0]    idx_i,
  output logic [AW-1:0]       addr_o
);
  logic [AW-1:0] base, offs;
  assign base = {frame_i, {OFF_W{1'b0}}};
  assign offs = AW'(idx_i) << ENT_LOG2;
  assign addr_o = base + offs;
endmodule

// File: rtl/ptw_entry_chk.sv
module ptw_entry_chk
  import ptw_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter bit LEAF = 1'b0
) (
  input  logic [DW-1:0] entry_i,
  input  logic          write_i,
  input  logic          user_i,
  output logic          fault_o,
  output logic          upd_o,
  output logic [DW-1:0] upd_data_o
);
  logic [DW-1:0] set_mask;
  logic          prot_bad;

  always_comb begin
    set_mask = '0;
    set_mask[BIT_ACCESSED] = 1'b1;
    if (LEAF) set_mask[BIT_DIRTY] = write_i;
  end

  assign prot_bad   = user_i && (!entry_i[BIT_USER] || (write_i && !entry_i[BIT_WRITABLE]));
  assign fault_o    = !entry_i[BIT_PRESENT] || prot_bad;
  assign upd_data_o = entry_i | set_mask;
  assign upd_o      = (entry_i & set_mask) != set_mask;
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned IDX_W = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [AW-1:0] req_lin_i,
  input  logic          req_write_i,
  input  logic          req_user_i,
  input  logic [AW-1:0] pdbr_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          fault_o,
  output logic [AW-1:0] phys_o,
  output logic [AW-1:0] fault_addr_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [AW-1:0] mem_wdata_o,
  input  logic          mem_ready_i,
  input  logic [AW-1:0] mem_rdata_i
);
  localparam int unsigned FRM_W = AW - OFF_W;
  localparam int unsigned TBL_LO = OFF_W;
  localparam int unsigned DIR_LO = OFF_W + IDX_W;

  walk_state_e   state_q;
  logic [AW-1:0] lin_q, ent_q, phys_q, fault_addr_q;
  logic [FRM_W-1:0] dir_base_q, tbl_base_q;
  logic          wr_q, usr_q, done_q, fault_q;

  logic [AW-1:0] dir_addr, tbl_addr;
  logic          dir_fault, dir_upd, tbl_fault, tbl_upd;
  logic [AW-1:0] dir_upd_data, tbl_upd_data;

  ptw_addr_gen #(.AW(AW), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_dir_addr (
    .frame_i(dir_base_q), .idx_i(lin_q[DIR_LO +: IDX_W]), .addr_o(dir_addr)
  );
  ptw_addr_gen #(.AW(AW), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_tbl_addr (
    .frame_i(tbl_base_q), .idx_i(lin_q[TBL_LO +: IDX_W]), .addr_o(tbl_addr)
  );

  ptw_entry_chk #(.DW(AW), .LEAF(1'b0)) u_dir_chk (
    .entry_i(mem_rdata_i), .write_i(wr_q), .user_i(usr_q),
    .fault_o(dir_fault), .upd_o(dir_upd), .upd_data_o(dir_upd_data)
  );
  ptw_entry_chk #(.DW(AW), .LEAF(1'b1)) u_tbl_chk (
    .entry_i(mem_rdata_i), .write_i(wr_q), .user_i(usr_q),
    .fault_o(tbl_fault), .upd_o(tbl_upd), .upd_data_o(tbl_upd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      lin_q        <= '0;
      ent_q        <= '0;
      phys_q       <= '0;
      fault_addr_q <= '0;
      dir_base_q   <= '0;
      tbl_base_q   <= '0;
      wr_q         <= 1'b0;
      usr_q        <= 1'b0;
      done_q       <= 1'b0;
      fault_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          lin_q      <= req_lin_i;
          wr_q       <= req_write_i;
          usr_q      <= req_user_i;
          dir_base_q <= pdbr_i[AW-1:OFF_W];
          state_q    <= ST_DIR_RD;
        end
        ST_DIR_RD: if (mem_ready_i) begin
          if (dir_fault) begin
            state_q      <= ST_IDLE;
            done_q       <= 1'b1;
            fault_q      <= 1'b1;
            fault_addr_q <= lin_q;
          end else begin
            tbl_base_q <= mem_rdata_i[AW-1:OFF_W];
            ent_q      <= dir_upd_data;
            state_q    <= dir_upd ? ST_DIR_WB : ST_TBL_RD;
          end
        end
        ST_DIR_WB: if (mem_ready_i) state_q <= ST_TBL_RD;
        ST_TBL_RD: if (mem_ready_i) begin
          if (tbl_fault) begin
            state_q      <= ST_IDLE;
            done_q       <= 1'b1;
            fault_q      <= 1'b1;
            fault_addr_q <= lin_q;
          end else if (tbl_upd) begin
            ent_q   <= tbl_upd_data;
            state_q <= ST_TBL_WB;
          end else begin
            phys_q  <= {mem_rdata_i[AW-1:OFF_W], lin_q[OFF_W-1:0]};
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            fault_q <= 1'b0;
          end
        end
        ST_TBL_WB: if (mem_ready_i) begin
          phys_q  <= {ent_q[AW-1:OFF_W], lin_q[OFF_W-1:0]};
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
          fault_q <= 1'b0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o       = state_q != ST_IDLE;
  assign done_o       = done_q;
  assign fault_o      = fault_q && done_q;
  assign phys_o       = phys_q;
  assign fault_addr_o = fault_addr_q;
  assign mem_req_o    = state_q != ST_IDLE;
  assign mem_we_o     = (state_q == ST_DIR_WB) || (state_q == ST_TBL_WB);
  assign mem_addr_o   = ((state_q == ST_DIR_RD) || (state_q == ST_DIR_WB)) ? dir_addr : tbl_addr;
  assign mem_wdata_o  = ent_q;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic [AW-1:0] req_lin_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          fault_o,
  input logic [AW-1:0] fault_addr_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [AW-1:0] mem_wdata_o,
  input logic          mem_ready_i
);
  logic [AW-1:0] cap_lin;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cap_lin <= '0;
    else if (req_valid_i && !busy_o) cap_lin <= req_lin_i;
  end

  assert_hold_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o));

  assert_word_align_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[1:0] == 2'b00);

  assert_req_in_walk_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);

  assert_done_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_done_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_fault_with_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> done_o);

  assert_fault_addr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> fault_addr_o == cap_lin);

  assert_wb_sets_access_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> mem_wdata_o[0] && mem_wdata_o[5]);
endmodule

bind ptw_walker ptw_walker_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_lin_i(req_lin_i),
  .busy_o(busy_o), .done_o(done_o), .fault_o(fault_o), .fault_addr_o(fault_addr_o),
  .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
  .mem_wdata_o(mem_wdata_o), .mem_ready_i(mem_ready_i)
);

// File: tb/ptw_walker_tb.sv
`timescale 1ns/1ps
module ptw_walker_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic [31:0] req_lin = '0, pdbr = '0;
  logic        busy_o, done_o, fault_o, mem_req_o, mem_we_o;
  logic [31:0] phys_o, fault_addr_o, mem_addr_o, mem_wdata_o;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_rdata = '0;

  ptw_walker u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_lin_i(req_lin),
    .req_write_i(req_write), .req_user_i(req_user), .pdbr_i(pdbr),
    .busy_o(busy_o), .done_o(done_o), .fault_o(fault_o), .phys_o(phys_o),
    .fault_addr_o(fault_addr_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_ready_i(mem_ready), .mem_rdata_i(mem_rdata)
  );

  typedef struct {
    logic [31:0] a;
    logic        we;
    logic [31:0] d;
    string       tag;
  } acc_t;

  acc_t        exp_q[$];
  logic [31:0] mem [logic [31:0]];
  int          checks = 0, errors = 0, cyc = 0, dly = 0, dly_sel = 0;
  bit          active = 1'b0, done_seen = 1'b0, exp_fault = 1'b0;
  logic [31:0] exp_phys = '0, exp_lin = '0;
  string       exp_tag = "";

  function automatic logic [31:0] rd(logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, expv);
    end
  endtask

  function automatic bit prot_bad(logic [31:0] e, bit w, bit u);
    return u && (!e[2] || (w && !e[1]));
  endfunction

  // behavioural model: expected access list and result of one walk
  function automatic void model(logic [31:0] lin, bit w, bit u, logic [31:0] base, string tag);
    logic [31:0] pa, pde, ta, pte, nv;
    exp_q.delete();
    exp_lin = lin;
    exp_tag = tag;
    exp_fault = 1'b0;
    pa = {base[31:12], 12'h0} + {20'h0, lin[31:22], 2'b00};
    exp_q.push_back('{pa, 1'b0, 32'h0, "R1 dir read"});
    pde = rd(pa);
    if (!pde[0] || prot_bad(pde, w, u)) begin exp_fault = 1'b1; return; end
    if (!pde[5]) exp_q.push_back('{pa, 1'b1, pde | 32'h20, "R5 dir write-back"});
    ta = {pde[31:12], 12'h0} + {20'h0, lin[21:12], 2'b00};
    exp_q.push_back('{ta, 1'b0, 32'h0, "R2 table read"});
    pte = rd(ta);
    if (!pte[0] || prot_bad(pte, w, u)) begin exp_fault = 1'b1; return; end
    nv = pte | 32'h20 | (w ? 32'h40 : 32'h0);
    if (nv != pte) exp_q.push_back('{ta, 1'b1, nv, "R6 table write-back"});
    exp_phys = {pte[31:12], lin[11:0]};
  endfunction

  // per-clock comparison and memory responder
  always @(negedge clk) begin
    if (rst_n) begin
      if (done_o) begin
        chk({exp_tag, " R8 busy low at done"}, {31'h0, busy_o}, 32'h0);
        chk({exp_tag, " R4 fault flag"}, {31'h0, fault_o}, {31'h0, exp_fault});
        if (exp_fault) chk({exp_tag, " R4 fault address"}, fault_addr_o, exp_lin);
        else chk({exp_tag, " R3 physical address"}, phys_o, exp_phys);
        chk({exp_tag, " R4 R6 accesses left"}, exp_q.size(), 0);
        active = 1'b0;
        done_seen = 1'b1;
      end else begin
        chk({exp_tag, " R8 busy"}, {31'h0, busy_o}, {31'h0, active});
      end
      mem_ready = 1'b0;
      if (mem_req_o) begin
        if (dly == 0) begin
          if (exp_q.size() == 0) begin
            errors++; checks++;
            $display("FAIL R4 R8 unexpected access actual %h expected none", mem_addr_o);
          end else begin
            acc_t e;
            e = exp_q.pop_front();
            chk({exp_tag, " ", e.tag, " addr"}, mem_addr_o, e.a);
            chk({exp_tag, " ", e.tag, " we"}, {31'h0, mem_we_o}, {31'h0, e.we});
            if (e.we) chk({exp_tag, " ", e.tag, " data"}, mem_wdata_o, e.d);
          end
          if (mem_we_o) mem[mem_addr_o] = mem_wdata_o;
          else mem_rdata = rd(mem_addr_o);
          mem_ready = 1'b1;
          dly_sel++;
          dly = dly_sel % 3;
        end else begin
          dly--;
        end
      end
    end
  end

  task automatic run(logic [31:0] lin, bit w, bit u, logic [31:0] base, string tag, bit poke = 1'b0);
    model(lin, w, u, base, tag);
    @(negedge clk);
    req_valid = 1'b1; req_lin = lin; req_write = w; req_user = u; pdbr = base;
    @(posedge clk);
    #1;
    active = 1'b1;
    done_seen = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      // R8: requests during a walk are ignored
      req_valid = 1'b1; req_lin = 32'h0080_0456; req_write = 1'b1; req_user = 1'b1;
      pdbr = 32'h0002_0000;
      @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
    end
    wait (done_seen);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++;
      $display("FAIL R8 watchdog actual busy expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  localparam logic [31:0] BASE = 32'h0001_0000;

  initial begin
    mem[32'h0001_0030] = 32'h0500_1027;
    mem[32'h0500_1040] = 32'h0300_0007;
    mem[32'h0001_0004] = 32'h0600_0007;
    mem[32'h0600_0000] = 32'h0700_0067;
    mem[32'h0001_0008] = 32'h0600_0006;
    mem[32'h0600_0004] = 32'h0700_1006;
    mem[32'h0600_0008] = 32'h0700_2023;
    mem[32'h0600_000C] = 32'h0700_3025;
    mem[32'h0001_000C] = 32'h0600_0023;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 busy", {31'h0, busy_o}, 32'h0);
    chk("R10 done", {31'h0, done_o}, 32'h0);
    chk("R10 fault", {31'h0, fault_o}, 32'h0);
    chk("R10 mem_req", {31'h0, mem_req_o}, 32'h0);
    chk("R10 fault_addr", fault_addr_o, 32'h0);
    rst_n = 1'b1;

    run(32'h0301_008A, 1'b0, 1'b0, BASE, "T1 worked example read");
    chk("T1 R3 worked example", phys_o, 32'h0300_008A);
    run(32'h0301_008A, 1'b1, 1'b0, BASE, "T2 write sets dirty");
    chk("T2 R6 dirty in memory", rd(32'h0500_1040), 32'h0300_0067);
    run(32'h0301_008A, 1'b1, 1'b0, BASE, "T3 no write-back");
    run(32'h0040_0123, 1'b1, 1'b1, BASE, "T4 dir accessed no dirty");
    chk("T4 R5 dir entry", rd(32'h0001_0004), 32'h0600_0027);
    run(32'h0080_0456, 1'b0, 1'b0, BASE, "T5 dir not present");
    run(32'h0040_1010, 1'b1, 1'b0, BASE, "T6 table not present");
    run(32'h0040_2000, 1'b0, 1'b1, BASE, "T7 R7 user on supervisor page");
    run(32'h0040_2000, 1'b1, 1'b0, BASE, "T7b R7 supervisor write allowed");
    run(32'h0040_3000, 1'b1, 1'b1, BASE, "T8 R7 user write read-only");
    run(32'h0040_3004, 1'b0, 1'b1, BASE, "T8b R7 user read read-only");
    run(32'h00C0_0000, 1'b0, 1'b1, BASE, "T9 R7 user dir supervisor");
    run(32'h00C0_0000, 1'b0, 1'b0, BASE, "T9b R7 supervisor dir");
    run(32'h0301_008A, 1'b0, 1'b0, BASE, "T10 R8 request while busy", 1'b1);
    run(32'h0301_008A, 1'b0, 1'b0, 32'h0002_0ABC, "T11 R1 other base fault");
    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule